// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This block handles the conditional-branch instruction class of a 16-bit processor. It picks the direction, external-select, invert and three-bit condition fields out of the instruction word. It tests the selected condition against the sign, zero, overflow and carry flags, or against a verdict that outside hardware returns. From the current program counter and the displacement word that follows the instruction, it works out where execution goes next.

A branch occupies two words: the instruction and its displacement. The counter input is the address of the instruction word. When the branch is not taken, execution continues two words further on. A forward target adds the displacement to that fall-through address. A backward target subtracts the displacement plus one from it.

In external mode the block drives a four-bit selector to outside logic during the same cycle. A single returned line then decides the branch, so up to sixteen outside conditions can be tested. The verdict, the class hit and the next counter are registered one clock after the inputs are presented. Fetching the instruction and displacement is left to the surrounding pipeline.

Top module: `branch_eval`

## Requirements
- R1: `br_hit` is 1 one clock after an instruction whose bits [15:6] equal 0b0000001000 is presented, and 0 for any other instruction.
- R2: Within a branch instruction, bit 5 selects backward (1) or forward (0), bit 4 selects external mode, bit 3 inverts the condition, and bits [2:0] pick the condition.
- R3: With the invert bit clear and external mode off, conditions 0..7 are taken when, respectively: always; C=1; O=1; S=0; Z=1; S xor O; Z or (S xor O); S xor C.
- R4: With the invert bit set and external mode off, each of the eight conditions gives the complement of its R3 verdict, so condition 0 is never taken.
- R5: In external mode, `ext_sel` equals {bit 3, bits [2:0]} in the same cycle, the verdict is the value of `ext_in`, and the flags have no effect.
- R6: `ext_sel` is 0 whenever the instruction is not an external-mode branch.
- R7: When no branch is taken, `next_pc` is `pc` + 2 modulo 2^16.
- R8: A taken forward branch gives `next_pc` = `pc` + 2 + `disp` modulo 2^16.
- R9: A taken backward branch gives `next_pc` = `pc` + 2 − `disp` − 1 modulo 2^16.
- R10: A non-branch instruction gives `taken` = 0, whatever the flags and `ext_in`.
- R11: `br_hit`, `taken` and `next_pc` are registered one clock after the inputs. A synchronous active-low reset clears all three to 0.
- R12: Flags enter as `flags[3]`=S, `flags[2]`=Z, `flags[1]`=O, `flags[0]`=C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction word under evaluation |
| disp | input | 16 | Displacement word following the instruction |
| pc | input | 16 | Address of the instruction word |
| flags | input | 4 | {S, Z, O, C} |
| ext_in | input | 1 | Verdict returned by outside hardware in external mode |
| ext_sel | output | 4 | Outside condition selector, 0 unless an external branch is present |
| br_hit | output | 1 | Registered: instruction is in the branch class |
| taken | output | 1 | Registered: branch taken |
| next_pc | output | 16 | Registered: next program counter |

## Verification
Directed vectors walk all eight conditions with the invert bit both clear and set, under flag settings that separate every pair of conditions. For example, S=1, O=1 splits less-than from sign-and-carry, and Z=1 splits less-or-equal from less-than. In external mode the flags are chosen to disagree with `ext_in`, which shows that the flags are ignored. Wrap-around corners cover a counter of 0xFFFF, a backward step with zero displacement, and a maximal displacement in both directions. Random vectors mix branch-class words with arbitrary words, so that near-miss opcodes are shown to yield neither a hit nor a taken branch.

// File: rtl/bce_pkg.sv
package bce_pkg;

   typedef enum logic [2:0] {
      CND_ALWAYS = 3'd0,
      CND_CARRY  = 3'd1,
      CND_OVF    = 3'd2,
      CND_PLUS   = 3'd3,
      CND_EQ     = 3'd4,
      CND_LT     = 3'd5,
      CND_LE     = 3'd6,
      CND_SGNCY  = 3'd7
   } cond_e;

   typedef struct packed {
      logic s;
      logic z;
      logic o;
      logic c;
   } flags_t;

   typedef struct packed {
      logic  hit;
      logic  back;
      logic  ext;
      logic  neg;
      cond_e cond;
   } brfields_t;

   localparam int SEL_W = 4;

endpackage

// File: rtl/bce_decode.sv
module bce_decode
   import bce_pkg::*;
#(
   parameter int INSTR_W   = 16,
   parameter int CLASS_LSB = 6,
   parameter int CLASS_VAL = 8
) (
   input  logic [INSTR_W-1:0] instr,
   output brfields_t          fld,
   output logic [SEL_W-1:0]   ext_sel
);

   localparam int TAG_W = INSTR_W - CLASS_LSB;
   localparam logic [TAG_W-1:0] TAG = TAG_W'(CLASS_VAL);

   generate
      if (CLASS_LSB != 6) begin : g_bad_lsb
         $error("bce_decode: field layout needs CLASS_LSB of 6");
      end
      if (TAG_W < 1) begin : g_bad_w
         $error("bce_decode: instruction too narrow");
      end
   endgenerate

   always_comb begin
      fld.hit  = (instr[INSTR_W-1:CLASS_LSB] == TAG);
      fld.back = instr[5];
      fld.ext  = instr[4];
      fld.neg  = instr[3];
      fld.cond = cond_e'(instr[2:0]);
   end

   always_comb begin
      if (fld.hit && fld.ext)
         ext_sel = {fld.neg, fld.cond};
      else
         ext_sel = '0;
   end

endmodule

// File: rtl/bce_cond_eval.sv
module bce_cond_eval
   import bce_pkg::*;
(
   input  flags_t    fl,
   input  brfields_t fld,
   input  logic      ext_in,
   output logic      pass
);

   logic raw;
   logic lt;

   assign lt = fl.s ^ fl.o;

   always_comb begin
      unique case (fld.cond)
         CND_ALWAYS: raw = 1'b1;
         CND_CARRY:  raw = fl.c;
         CND_OVF:    raw = fl.o;
         CND_PLUS:   raw = ~fl.s;
         CND_EQ:     raw = fl.z;
         CND_LT:     raw = lt;
         CND_LE:     raw = fl.z | lt;
         CND_SGNCY:  raw = fl.s ^ fl.c;
         default:    raw = 1'b0;
      endcase
   end

   assign pass = fld.ext ? ext_in : (raw ^ fld.neg);

endmodule

// File: rtl/bce_target.sv
module bce_target #(
   parameter int ADDR_W    = 16,
   parameter int DISP_W    = 16,
   parameter int FALL_STEP = 2
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   input  logic              back,
   input  logic              take,
   output logic [ADDR_W-1:0] nxt
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(FALL_STEP);
   localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

   logic [ADDR_W-1:0] disp_x;
   logic [ADDR_W-1:0] fall;
   logic [ADDR_W-1:0] fwd;
   logic [ADDR_W-1:0] bwd;

   generate
      if (DISP_W > ADDR_W) begin : g_bad
         $error("bce_target: displacement wider than address");
      end
      if (DISP_W == ADDR_W) begin : g_same
         assign disp_x = disp;
      end else begin : g_ext
         assign disp_x = {{(ADDR_W-DISP_W){1'b0}}, disp};
      end
   endgenerate

   assign fall = pc + STEP;
   assign fwd  = fall + disp_x;
   assign bwd  = fall - disp_x - ONE;
   assign nxt  = !take ? fall : (back ? bwd : fwd);

endmodule

// File: rtl/branch_eval.sv
module branch_eval
   import bce_pkg::*;
#(
   parameter int INSTR_W = 16,
   parameter int ADDR_W  = 16,
   parameter int DISP_W  = 16,
   parameter int OUT_REG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] pc,
   input  logic [3:0]        flags,
   input  logic              ext_in,
   output logic [3:0]        ext_sel,
   output logic              br_hit,
   output logic              taken,
   output logic [ADDR_W-1:0] next_pc
);

   localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] UNO = ADDR_W'(1);

   generate
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_reg
         $error("branch_eval: OUT_REG must be 0 or 1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("branch_eval: address too narrow");
      end
   endgenerate

   brfields_t fld;
   flags_t    fl;
   logic      pass;
   logic      go;
   logic [ADDR_W-1:0] nxt;

   assign fl = flags_t'(flags);

   bce_decode #(.INSTR_W(INSTR_W)) u_dec (
      .instr   (instr),
      .fld     (fld),
      .ext_sel (ext_sel)
   );

   bce_cond_eval u_cond (
      .fl     (fl),
      .fld    (fld),
      .ext_in (ext_in),
      .pass   (pass)
   );

   assign go = fld.hit & pass;

   bce_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
      .pc   (pc),
      .disp (disp),
      .back (fld.back),
      .take (go),
      .nxt  (nxt)
   );

   generate
      if (OUT_REG == 1) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               br_hit  <= 1'b0;
               taken   <= 1'b0;
               next_pc <= '0;
            end else begin
               br_hit  <= fld.hit;
               taken   <= go;
               next_pc <= nxt;
            end
         end

         // R10
         nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !fld.hit |=> (!taken && !br_hit));

         // R7
         fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !go |=> (next_pc == $past(pc) + TWO));

         // R9
         backward_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (go && fld.back) |=> (next_pc == $past(pc) + TWO - ADDR_W'($past(disp)) - UNO));

         // R4
         never_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fld.hit && !fld.ext && fld.neg && fld.cond == CND_ALWAYS) |=> !taken);

         // R5
         ext_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fld.hit && fld.ext) |=> (taken == $past(ext_in)));

         // R6
         sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(fld.hit && fld.ext) |-> (ext_sel == 4'd0));
      end else begin : g_comb
         assign br_hit  = fld.hit;
         assign taken   = go;
         assign next_pc = nxt;
      end
   endgenerate

endmodule

// File: tb/branch_eval_test.sv
module branch_eval_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr = '0;
   logic [15:0] disp = '0;
   logic [15:0] pc = '0;
   logic [3:0]  flags = '0;
   logic        ext_in = 1'b0;
   logic [3:0]  ext_sel;
   logic        br_hit;
   logic        taken;
   logic [15:0] next_pc;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   branch_eval uut (
      .clk(clk), .rst_n(rst_n), .instr(instr), .disp(disp), .pc(pc),
      .flags(flags), .ext_in(ext_in), .ext_sel(ext_sel), .br_hit(br_hit),
      .taken(taken), .next_pc(next_pc)
   );

   function automatic bit is_br(input logic [15:0] i);
      return i[15:6] == 10'b0000001000;
   endfunction

   function automatic bit m_taken(input logic [15:0] i, input logic [3:0] f, input bit x);
      bit s, z, o, c, r;
      if (!is_br(i)) return 1'b0;
      if (i[4]) return x;
      s = f[3]; z = f[2]; o = f[1]; c = f[0];
      case (i[2:0])
         3'd0: r = 1'b1;
         3'd1: r = c;
         3'd2: r = o;
         3'd3: r = !s;
         3'd4: r = z;
         3'd5: r = s ^ o;
         3'd6: r = z | (s ^ o);
         default: r = s ^ c;
      endcase
      return r ^ i[3];
   endfunction

   function automatic logic [15:0] m_pc(input logic [15:0] i, input logic [15:0] d,
                                        input logic [15:0] p, input bit t);
      logic [15:0] f;
      f = p + 16'd2;
      if (!t) return f;
      if (i[5]) return f - d - 16'd1;
      return f + d;
   endfunction

   function automatic logic [3:0] m_sel(input logic [15:0] i);
      if (is_br(i) && i[4]) return i[3:0];
      return 4'd0;
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] i, input logic [15:0] d, input logic [15:0] p,
                        input logic [3:0] f, input bit x, input string extra);
      bit          et;
      logic [15:0] ep;
      logic [3:0]  es;
      string       tt, tp;
      @(negedge clk);
      instr = i; disp = d; pc = p; flags = f; ext_in = x;
      et = m_taken(i, f, x);
      ep = m_pc(i, d, p, et);
      es = m_sel(i);
      #1;
      check(ext_sel == es, (is_br(i) && i[4]) ? "R5 sel" : "R6 sel", 32'(ext_sel), 32'(es));
      @(negedge clk);
      if (!is_br(i)) tt = "R10";
      else if (i[4]) tt = "R5";
      else if (i[3]) tt = "R4";
      else tt = "R3 R12";
      if (!et) tp = "R7";
      else if (i[5]) tp = "R9";
      else tp = "R8";
      check(br_hit == is_br(i), "R1", 32'(br_hit), 32'(is_br(i)));
      check(taken == et, {tt, " ", extra}, 32'(taken), 32'(et));
      check(next_pc == ep, {tp, " R11 ", extra}, 32'(next_pc), 32'(ep));
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state
      check(br_hit == 1'b0 && taken == 1'b0 && next_pc == 16'd0, "R11 reset",
            {15'd0, br_hit, taken}, 32'd0);
      rst_n = 1'b1;

      // R3 / R4: each condition, both polarities, under separating flags
      for (int fv = 0; fv < 16; fv++) begin
         for (int cv = 0; cv < 16; cv++) begin
            apply(16'h0200 | 16'(cv), 16'h0010, 16'h4000, 4'(fv), 1'b0, "cond sweep");
         end
      end

      // R2: direction bit flips target, same condition
      apply(16'h0200, 16'h0005, 16'h1000, 4'h0, 1'b0, "R2 fwd");
      check(next_pc == 16'h1007, "R2 forward", 32'(next_pc), 32'h1007);
      apply(16'h0220, 16'h0005, 16'h1000, 4'h0, 1'b0, "R2 back");
      check(next_pc == 16'h0FFC, "R2 backward", 32'(next_pc), 32'h0FFC);

      // R5: external mode, flags set to disagree
      for (int cv = 0; cv < 16; cv++) begin
         apply(16'h0210 | 16'(cv), 16'h0003, 16'h2000, 4'hF, 1'b0, "ext lo");
         apply(16'h0210 | 16'(cv), 16'h0003, 16'h2000, 4'h0, 1'b1, "ext hi");
      end

      // wrap corners, R7 R8 R9
      apply(16'h0208, 16'h0000, 16'hFFFF, 4'h0, 1'b0, "pc wrap fall");
      apply(16'h0220, 16'h0000, 16'h0000, 4'h0, 1'b0, "back zero disp");
      apply(16'h0220, 16'hFFFF, 16'h0010, 4'h0, 1'b0, "back max disp");
      apply(16'h0200, 16'hFFFF, 16'hFFF0, 4'h0, 1'b0, "fwd wrap");

      // R10: near-miss opcodes
      apply(16'h0240, 16'h0001, 16'h3000, 4'hF, 1'b1, "near miss hi");
      apply(16'h01F0, 16'h0001, 16'h3000, 4'hF, 1'b1, "near miss lo");
      apply(16'h8200, 16'h0001, 16'h3000, 4'hF, 1'b1, "upper bit");

      // random mix
      for (int k = 0; k < 3000; k++) begin
         logic [15:0] ri;
         if ($urandom_range(0, 3) != 0) ri = 16'h0200 | 16'($urandom_range(0, 63));
         else ri = 16'($urandom);
         apply(ri, 16'($urandom), 16'($urandom), 4'($urandom), 1'($urandom), "random");
      end

      // R11: reset mid-run clears registered outputs
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(br_hit == 1'b0 && taken == 1'b0 && next_pc == 16'd0, "R11 re-reset",
            {15'd0, br_hit, taken}, 32'd0);
      finish_run();
   end

endmodule